// File: doc/BRIEF.md
# Link Training Retry Sequencer

This block brings up a point-to-point serial link by stepping a transmitter and a receiver through a two-phase training handshake. In the first phase both sides send training pattern 1 until the receiver reports bit lock. In the second phase they switch to training pattern 2 until the receiver reports symbol lock. Each phase waits a settle interval before every lock sample and takes at most four samples. The lock status flags are sticky and are cleared by write-one-to-clear strobes that the sequencer pulses.

Training walks a table of four drive-strength settings and tries each setting twice, for up to eight attempts. Every attempt starts from a quiet cycle with both ends disabled. A failure in either phase moves on to the next attempt. When all attempts are used up, the sequencer pulses a fail output and returns to idle. On success it holds the link enabled and raises done until the next start. All delays are cycle counts derived from a clock-frequency parameter.

States: `ST_IDLE`, `ST_QUIESCE`, `ST_TX_ON`, `ST_RX_ON`, `ST_P1_WAIT`, `ST_P1_READ`, `ST_P1_JUDGE`, `ST_P2_SWITCH`, `ST_P2_WAIT`, `ST_P2_READ`, `ST_P2_JUDGE`, `ST_LOCKED`, `ST_GIVEUP`.

Transitions:
- IDLE→QUIESCE on start.
- QUIESCE→TX_ON→RX_ON→P1_WAIT unconditionally.
- P1_WAIT→P1_READ when the settle timer expires.
- P1_READ→P1_JUDGE.
- P1_JUDGE goes to:
  - P2_SWITCH on a hit;
  - P1_WAIT on a miss with samples left;
  - QUIESCE on a miss at the last sample with attempts left;
  - GIVEUP on a miss at the last sample of the last attempt.
- P2_SWITCH→P2_WAIT.
- P2_WAIT→P2_READ when the settle timer expires.
- P2_READ→P2_JUDGE.
- P2_JUDGE goes to LOCKED on a hit; otherwise it follows the same miss rules as phase 1.
- LOCKED→QUIESCE on start.
- GIVEUP→IDLE.

Top module: `link_train_seq`

## Requirements
- R1: After reset, and in idle, both enables are low, both pattern selects are 2'b00, done and fail are low, and the lock flags are ignored: no clear strobe appears while idle.
- R2: Each attempt opens with one cycle in which both enables are low and both patterns are 2'b00. The next cycle enables only the transmitter, with pattern 2'b01 and the lane count captured from lane_cfg. The cycle after that also enables the receiver with pattern 2'b01.
- R3: rx_en is never high while tx_en is low, and tx_pat is never 2'b00 while tx_en is high.
- R4: Counting the cycle in which the receiver is enabled as cycle 0, bit lock is captured at the end of cycle 1+T1+s*(T1+2) for samples s = 0..3. T1 = ceil(P1_NS × CLK_KHZ / 10^6) cycles, which is 25 with the defaults.
- R5: A sample passes if the captured flag is set, or if the live flag is set in the following judge cycle.
- R6: On a pass, the clear strobe for that flag is high for exactly the judge cycle. No clear strobe is raised in a read cycle.
- R7: If bit lock misses all four samples, both enables drop in the next cycle and a new attempt begins.
- R8: After bit lock, the next cycle sets both patterns to 2'b10 and keeps the drive index. Symbol lock is then sampled like bit lock but with T2 = ceil(P2_NS × CLK_KHZ / 10^6), which is 75 with the defaults.
- R9: A symbol-lock pass raises done in the next cycle. Four symbol-lock misses drop both enables in the next cycle and start the next attempt.
- R10: drive_idx equals the attempt number (0..7) divided by 2.
- R11: After the eighth failed attempt, fail is high for exactly one cycle with both enables low, and the block then returns to idle.
- R12: done and the enables hold until a start arrives. A start while training is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse (honoured in idle or locked) |
| lane_cfg | input | LANE_W | Lane count to load into the transmitter |
| bit_lock | input | 1 | Sticky bit-lock flag from the receiver |
| sym_lock | input | 1 | Sticky symbol-lock flag from the receiver |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| tx_pat | output | 2 | Transmitter pattern: 00 off, 01 pattern 1, 10 pattern 2 |
| rx_pat | output | 2 | Receiver pattern, same encoding |
| tx_lanes | output | LANE_W | Lane count latched at the start of the attempt |
| drive_idx | output | DRV_W | Selected drive-strength table index |
| bit_lock_clr | output | 1 | Write-one-to-clear strobe for bit lock |
| sym_lock_clr | output | 1 | Write-one-to-clear strobe for symbol lock |
| done | output | 1 | Training succeeded; held until next start |
| fail | output | 1 | One-cycle pulse when all attempts fail |

## Verification
The assertions assume the lock flags behave as sticky status that only rises while the matching pattern is being sent, and that start arrives as a single-cycle pulse. The bench keeps within this by acting as the receiver. It raises a flag only in the exact read or judge cycle it wants to test, and drops the flag one cycle after the clear strobe. It issues start pulses only in idle, in the locked state, or deliberately in the middle of a phase-1 wait to show that they are ignored.

// File: rtl/lt_pkg.sv
`timescale 1ns/1ps
package lt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_QUIESCE,
        ST_TX_ON,
        ST_RX_ON,
        ST_P1_WAIT,
        ST_P1_READ,
        ST_P1_JUDGE,
        ST_P2_SWITCH,
        ST_P2_WAIT,
        ST_P2_READ,
        ST_P2_JUDGE,
        ST_LOCKED,
        ST_GIVEUP
    } lt_state_e;

    localparam logic [1:0] PAT_OFF = 2'b00;
    localparam logic [1:0] PAT_ONE = 2'b01;
    localparam logic [1:0] PAT_TWO = 2'b10;

    // Whole cycles covering a delay in ns, rounded up, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned khz);
        longint unsigned prod;
        longint unsigned cyc;
        prod = longint'(ns) * longint'(khz);
        cyc  = (prod + 64'd999999) / 64'd1000000;
        if (cyc == 0) cyc = 1;
        return int'(cyc);
    endfunction

endpackage

// File: rtl/lt_settle_timer.sv
`timescale 1ns/1ps
module lt_settle_timer #(
    parameter int unsigned SHORT_CYC = 25,
    parameter int unsigned LONG_CYC  = 75
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic use_long,
    output logic expired
);
    localparam int unsigned MAXC = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
    localparam int unsigned CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit   = use_long ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
    assign expired = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lt_step_ctr.sv
`timescale 1ns/1ps
module lt_step_ctr #(
    parameter  int unsigned COUNT = 8,
    localparam int unsigned W     = (COUNT > 1) ? $clog2(COUNT) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         at_last
);
    assign at_last = (value == W'(COUNT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (inc && !at_last) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/link_train_seq.sv
`timescale 1ns/1ps
module link_train_seq
    import lt_pkg::*;
#(
    parameter  int unsigned CLK_KHZ         = 50000,
    parameter  int unsigned P1_NS           = 500,
    parameter  int unsigned P2_NS           = 1500,
    parameter  int unsigned DRIVE_ENTRIES   = 4,
    parameter  int unsigned TRIES_PER_ENTRY = 2,
    parameter  int unsigned LOCK_SAMPLES    = 4,
    parameter  int unsigned LANE_W          = 3,
    localparam int unsigned DRV_W           = (DRIVE_ENTRIES > 1) ? $clog2(DRIVE_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LANE_W-1:0] lane_cfg,
    input  logic              bit_lock,
    input  logic              sym_lock,
    output logic              tx_en,
    output logic              rx_en,
    output logic [1:0]        tx_pat,
    output logic [1:0]        rx_pat,
    output logic [LANE_W-1:0] tx_lanes,
    output logic [DRV_W-1:0]  drive_idx,
    output logic              bit_lock_clr,
    output logic              sym_lock_clr,
    output logic              done,
    output logic              fail
);
    localparam int unsigned ATTEMPTS = DRIVE_ENTRIES * TRIES_PER_ENTRY;
    localparam int unsigned AT_W     = (ATTEMPTS > 1) ? $clog2(ATTEMPTS) : 1;
    localparam int unsigned SM_W     = (LOCK_SAMPLES > 1) ? $clog2(LOCK_SAMPLES) : 1;
    localparam int unsigned T1_CYC   = ns_to_cycles(P1_NS, CLK_KHZ);
    localparam int unsigned T2_CYC   = ns_to_cycles(P2_NS, CLK_KHZ);

    lt_state_e state, nxt;

    logic            lock_cap;
    logic            hit1, hit2;
    logic            tmr_run, tmr_long, tmr_exp;
    logic            att_clr, att_inc, att_last;
    logic [AT_W-1:0] attempt;
    logic            smp_clr, smp_inc, smp_last;
    logic [SM_W-1:0] sample;

    assign hit1 = lock_cap | bit_lock;
    assign hit2 = lock_cap | sym_lock;

    lt_settle_timer #(.SHORT_CYC(T1_CYC), .LONG_CYC(T2_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tmr_run),
        .use_long (tmr_long),
        .expired  (tmr_exp)
    );

    lt_step_ctr #(.COUNT(ATTEMPTS)) u_attempts (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (att_clr),
        .inc     (att_inc),
        .value   (attempt),
        .at_last (att_last)
    );

    lt_step_ctr #(.COUNT(LOCK_SAMPLES)) u_samples (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (smp_clr),
        .inc     (smp_inc),
        .value   (sample),
        .at_last (smp_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // captured lock sample and latched lane count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_cap <= 1'b0;
            tx_lanes <= '0;
        end else begin
            if (state == ST_P1_READ) lock_cap <= bit_lock;
            if (state == ST_P2_READ) lock_cap <= sym_lock;
            if (state == ST_QUIESCE) tx_lanes <= lane_cfg;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start) nxt = ST_QUIESCE;
            ST_QUIESCE:   nxt = ST_TX_ON;
            ST_TX_ON:     nxt = ST_RX_ON;
            ST_RX_ON:     nxt = ST_P1_WAIT;
            ST_P1_WAIT:   if (tmr_exp) nxt = ST_P1_READ;
            ST_P1_READ:   nxt = ST_P1_JUDGE;
            ST_P1_JUDGE: begin
                if (hit1)           nxt = ST_P2_SWITCH;
                else if (!smp_last) nxt = ST_P1_WAIT;
                else if (att_last)  nxt = ST_GIVEUP;
                else                nxt = ST_QUIESCE;
            end
            ST_P2_SWITCH: nxt = ST_P2_WAIT;
            ST_P2_WAIT:   if (tmr_exp) nxt = ST_P2_READ;
            ST_P2_READ:   nxt = ST_P2_JUDGE;
            ST_P2_JUDGE: begin
                if (hit2)           nxt = ST_LOCKED;
                else if (!smp_last) nxt = ST_P2_WAIT;
                else if (att_last)  nxt = ST_GIVEUP;
                else                nxt = ST_QUIESCE;
            end
            ST_LOCKED:    if (start) nxt = ST_QUIESCE;
            ST_GIVEUP:    nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // outputs and counter controls
    always_comb begin
        tx_en        = 1'b0;
        rx_en        = 1'b0;
        tx_pat       = PAT_OFF;
        rx_pat       = PAT_OFF;
        bit_lock_clr = 1'b0;
        sym_lock_clr = 1'b0;
        done         = 1'b0;
        fail         = 1'b0;
        tmr_run      = 1'b0;
        tmr_long     = 1'b0;
        att_clr      = 1'b0;
        att_inc      = 1'b0;
        smp_clr      = 1'b0;
        smp_inc      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                att_clr = start;
            end
            ST_QUIESCE: begin
                smp_clr = 1'b1;
            end
            ST_TX_ON: begin
                tx_en  = 1'b1;
                tx_pat = PAT_ONE;
            end
            ST_RX_ON, ST_P1_READ: begin
                tx_en  = 1'b1;
                rx_en  = 1'b1;
                tx_pat = PAT_ONE;
                rx_pat = PAT_ONE;
            end
            ST_P1_WAIT: begin
                tx_en   = 1'b1;
                rx_en   = 1'b1;
                tx_pat  = PAT_ONE;
                rx_pat  = PAT_ONE;
                tmr_run = 1'b1;
            end
            ST_P1_JUDGE: begin
                tx_en        = 1'b1;
                rx_en        = 1'b1;
                tx_pat       = PAT_ONE;
                rx_pat       = PAT_ONE;
                bit_lock_clr = hit1;
                smp_inc      = !hit1 && !smp_last;
                att_inc      = !hit1 && smp_last && !att_last;
            end
            ST_P2_SWITCH: begin
                tx_en   = 1'b1;
                rx_en   = 1'b1;
                tx_pat  = PAT_TWO;
                rx_pat  = PAT_TWO;
                smp_clr = 1'b1;
            end
            ST_P2_WAIT: begin
                tx_en    = 1'b1;
                rx_en    = 1'b1;
                tx_pat   = PAT_TWO;
                rx_pat   = PAT_TWO;
                tmr_run  = 1'b1;
                tmr_long = 1'b1;
            end
            ST_P2_READ: begin
                tx_en  = 1'b1;
                rx_en  = 1'b1;
                tx_pat = PAT_TWO;
                rx_pat = PAT_TWO;
            end
            ST_P2_JUDGE: begin
                tx_en        = 1'b1;
                rx_en        = 1'b1;
                tx_pat       = PAT_TWO;
                rx_pat       = PAT_TWO;
                sym_lock_clr = hit2;
                smp_inc      = !hit2 && !smp_last;
                att_inc      = !hit2 && smp_last && !att_last;
            end
            ST_LOCKED: begin
                tx_en   = 1'b1;
                rx_en   = 1'b1;
                tx_pat  = PAT_TWO;
                rx_pat  = PAT_TWO;
                done    = 1'b1;
                att_clr = start;
            end
            ST_GIVEUP: begin
                fail = 1'b1;
            end
            default: begin
                fail = 1'b0;
            end
        endcase
    end

    assign drive_idx = DRV_W'(attempt / AT_W'(TRIES_PER_ENTRY));

endmodule

// File: rtl/lt_seq_checker.sv
`timescale 1ns/1ps
module lt_seq_checker #(
    parameter int unsigned DRV_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             tx_en,
    input logic             rx_en,
    input logic [1:0]       tx_pat,
    input logic [1:0]       rx_pat,
    input logic [DRV_W-1:0] drive_idx,
    input logic             bit_lock_clr,
    input logic             sym_lock_clr,
    input logic             done,
    input logic             fail
);
    p_rx_needs_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |-> tx_en);

    p_pat_when_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> (tx_pat != 2'b00));

    p_tx_leads_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_en) |-> ($past(tx_en) && rx_pat == 2'b01));

    p_bit_clr_to_pat2_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_lock_clr |=> (rx_pat == 2'b10 && tx_pat == 2'b10));

    p_sym_clr_to_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sym_lock_clr |=> done);

    p_drive_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en)) |-> $stable(drive_idx));

    p_fail_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail);

    p_fail_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (!tx_en && !rx_en && !done));

    p_done_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

bind link_train_seq lt_seq_checker #(.DRV_W(DRV_W)) u_seq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .tx_en        (tx_en),
    .rx_en        (rx_en),
    .tx_pat       (tx_pat),
    .rx_pat       (rx_pat),
    .drive_idx    (drive_idx),
    .bit_lock_clr (bit_lock_clr),
    .sym_lock_clr (sym_lock_clr),
    .done         (done),
    .fail         (fail)
);

// File: tb/test_link_train_seq.sv
`timescale 1ns/1ps
module test_link_train_seq;
    localparam int LANE_W = 3;
    localparam int CLK_KHZ = 50000;
    localparam int T1 = (500 * CLK_KHZ + 999999) / 1000000;
    localparam int T2 = (1500 * CLK_KHZ + 999999) / 1000000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LANE_W-1:0] lane_cfg = '0;
    logic bit_lock = 1'b0;
    logic sym_lock = 1'b0;
    logic tx_en, rx_en, bit_lock_clr, sym_lock_clr, done, fail;
    logic [1:0] tx_pat, rx_pat;
    logic [LANE_W-1:0] tx_lanes;
    logic [1:0] drive_idx;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    link_train_seq i_link_train_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .lane_cfg(lane_cfg),
        .bit_lock(bit_lock), .sym_lock(sym_lock),
        .tx_en(tx_en), .rx_en(rx_en), .tx_pat(tx_pat), .rx_pat(rx_pat),
        .tx_lanes(tx_lanes), .drive_idx(drive_idx),
        .bit_lock_clr(bit_lock_clr), .sym_lock_clr(sym_lock_clr),
        .done(done), .fail(fail)
    );

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // One attempt; p1s/p2s = sample index that passes, 4 = never.
    task automatic do_attempt(input int att, input int p1s, input bit p1late,
                              input int p2s, input bit p2late, input bit last_att);
        int n;
        int guard;
        int rd;
        bit quiet;
        bit ptx;
        bit hit;
        quiet = 0; ptx = 0; guard = 0;
        while (rx_en !== 1'b1 && guard < 4000) begin
            if (!tx_en && !rx_en && tx_pat == 2'b00 && rx_pat == 2'b00) quiet = 1;
            ptx = tx_en;
            @(negedge clk);
            guard++;
        end
        chk_eq("R2", "quiet cycle before attempt", int'(quiet), 1);
        chk_eq("R2", "tx enabled one cycle before rx", int'(ptx), 1);
        chk_eq("R2", "tx pattern 1", int'(tx_pat), 1);
        chk_eq("R2", "rx pattern 1", int'(rx_pat), 1);
        chk_eq("R2", "lane count", int'(tx_lanes), int'(lane_cfg));
        chk_eq("R10", "drive index", int'(drive_idx), att / 2);

        n = 0; hit = 0;
        for (int s = 0; s < 4 && !hit; s++) begin
            rd = 1 + T1 + s * (T1 + 2);
            while (n < rd) begin @(negedge clk); n++; end
            if (s == p1s && !p1late) bit_lock = 1'b1;
            #1;
            chk_eq("R4", "no bit clear in read cycle", int'(bit_lock_clr), 0);
            @(negedge clk); n++;
            if (s == p1s && p1late) bit_lock = 1'b1;
            #1;
            chk_eq(p1late ? "R5" : "R6", "bit clear in judge cycle",
                   int'(bit_lock_clr), int'(s == p1s));
            hit = (s == p1s);
        end
        @(negedge clk);
        bit_lock = 1'b0;
        if (!hit) begin
            chk_eq("R7", "enables low after bit-lock miss", int'(tx_en | rx_en), 0);
            chk_eq("R11", "fail only on last attempt", int'(fail), int'(last_att));
            if (last_att) begin
                @(negedge clk);
                chk_eq("R11", "fail lasts one cycle", int'(fail), 0);
                chk_eq("R11", "idle after fail", int'(tx_en | rx_en | done), 0);
            end
            return;
        end
        chk_eq("R8", "tx pattern 2", int'(tx_pat), 2);
        chk_eq("R8", "rx pattern 2", int'(rx_pat), 2);
        chk_eq("R8", "drive index kept", int'(drive_idx), att / 2);

        n = 0; hit = 0;
        for (int s = 0; s < 4 && !hit; s++) begin
            rd = 1 + T2 + s * (T2 + 2);
            while (n < rd) begin @(negedge clk); n++; end
            if (s == p2s && !p2late) sym_lock = 1'b1;
            #1;
            chk_eq("R8", "no symbol clear in read cycle", int'(sym_lock_clr), 0);
            @(negedge clk); n++;
            if (s == p2s && p2late) sym_lock = 1'b1;
            #1;
            chk_eq(p2late ? "R5" : "R6", "symbol clear in judge cycle",
                   int'(sym_lock_clr), int'(s == p2s));
            hit = (s == p2s);
        end
        @(negedge clk);
        sym_lock = 1'b0;
        if (hit) begin
            chk_eq("R9", "done after symbol lock", int'(done), 1);
        end else begin
            chk_eq("R9", "enables low after symbol-lock miss", int'(tx_en | rx_en), 0);
            chk_eq("R11", "fail only on last attempt", int'(fail), int'(last_att));
            if (last_att) begin
                @(negedge clk);
                chk_eq("R11", "fail lasts one cycle", int'(fail), 0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        lane_cfg = 3'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1", "enables after reset", int'(tx_en | rx_en), 0);
        chk_eq("R1", "patterns after reset", int'(tx_pat | rx_pat), 0);
        chk_eq("R1", "done/fail after reset", int'(done | fail), 0);
        bit_lock = 1'b1; sym_lock = 1'b1;
        repeat (5) @(negedge clk);
        chk_eq("R1", "no clear strobe in idle", int'(bit_lock_clr | sym_lock_clr), 0);
        chk_eq("R1", "idle ignores flags", int'(tx_en | rx_en), 0);
        bit_lock = 1'b0; sym_lock = 1'b0;

        // first-try pass with a start during phase 1 (R12)
        pulse_start();
        fork
            do_attempt(0, 0, 0, 0, 0, 0);
            begin
                repeat (12) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        repeat (30) @(negedge clk);
        chk_eq("R12", "done holds", int'(done), 1);
        chk_eq("R12", "enables hold", int'(tx_en & rx_en), 1);

        // retries across attempts, restart from locked
        lane_cfg = 3'd5;
        pulse_start();
        chk_eq("R12", "done cleared by start", int'(done), 0);
        do_attempt(0, 4, 0, 0, 0, 0);
        do_attempt(1, 2, 1, 4, 0, 0);
        do_attempt(2, 3, 0, 1, 1, 0);

        // sweep of sample positions and capture paths
        for (int s = 0; s < 4; s++) begin
            for (int late = 0; late < 2; late++) begin
                lane_cfg = LANE_W'(s + 2 * late);
                pulse_start();
                do_attempt(0, s, late[0], 3 - s, !late[0], 0);
            end
        end

        // every attempt fails
        lane_cfg = 3'd1;
        pulse_start();
        for (int a = 0; a < 8; a++) begin
            do_attempt(a, (a % 2 == 1) ? (a % 4) : 4, 0, 4, 0, a == 7);
        end
        repeat (5) @(negedge clk);
        chk_eq("R11", "still idle", int'(tx_en | rx_en | done | fail), 0);

        // restart from idle, pass on the last attempt
        lane_cfg = 3'd7;
        pulse_start();
        for (int a = 0; a < 7; a++) do_attempt(a, 4, 0, 0, 0, 0);
        do_attempt(7, 1, 0, 2, 0, 1);
        chk_eq("R10", "last drive index at lock", int'(drive_idx), 3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule